// File: doc/BRIEF.md
# Auto-Detecting Serial Register Port

This block connects an external host controller to a chip's internal register bus over a four-wire serial link. It serves register reads, register writes and writes into a program memory. Each chip-select assertion opens one transaction of sixteen serial bits. The first byte carries a read/write flag, a target-space flag and an address. The second byte carries the write data, or it returns the read data.

The block does not use a fixed wire protocol. Each time chip select goes low, it looks at the level of the serial clock and chooses between two conventions for that transaction:

- **Shift-register mode** (clock idles high): least significant bit first, over one shared bidirectional data pin.
- **SPI mode 0 style**: most significant bit first, with separate receive and transmit pins.

All pins are oversampled by a fast system clock through synchronizers. The serial clock half-period must span at least six system clock cycles.

Top module: `srp_host_port`

## Requirements
- R1: On every high-to-low transition of `cs_n`, the mode for the whole transaction is chosen from `sclk`. High selects the shift-register mode and low selects the SPI mode; the choice is held until `cs_n` rises.
- R2: In shift-register mode, bits are sampled on rising `sclk` from `dq1_i`, least significant bit first, and `d2_i` has no effect.
- R3: In SPI mode, bits are sampled on rising `sclk` from `d2_i`, most significant bit first. Read data leaves on `dq1_o`, and `dq1_oe` is high for the whole time chip select is active.
- R4: The command byte layout is: bit 7 = 1 for a read and 0 for a write, bit 6 = 1 for the program-memory space and 0 for the register space, bits 5:0 = address, presented on `bus_addr`.
- R5: A register-space write produces exactly one single-cycle `reg_wr` pulse after the 16th rising `sclk` edge, with `bus_addr` and `bus_wdata` holding the received address and data.
- R6: A program-space write produces one `pmem_wr` pulse instead, and no `reg_wr`.
- R7: A register-space read produces one single-cycle `reg_rd` pulse after the 8th rising `sclk` edge. `bus_rdata` is taken in the following system cycle, and its bits leave on `dq1_o`, each new bit appearing after a falling `sclk` edge, in the bit order of the mode.
- R8: A program-space read raises no `reg_rd` and returns 0x00.
- R9: In shift-register mode, `dq1_oe` is high only during the data byte of a read: from the 8th rising edge to the 16th rising edge or to chip-select release. It is never high while chip select is inactive.
- R10: Releasing `cs_n` before the 16th rising edge aborts the transaction without any bus pulse. The next transaction starts again from bit zero.
- R11: During and after reset, `dq1_oe`, `dq1_o`, `reg_wr`, `reg_rd`, `pmem_wr`, `bus_addr` and `bus_wdata` are all zero.
- R12: Serial clocks after the 16th rising edge in one transaction are ignored and cause no second bus pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples every serial pin |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| dq1_i | input | 1 | Data pin 1 input (shift-register mode receive) |
| dq1_o | output | 1 | Data pin 1 output value |
| dq1_oe | output | 1 | Data pin 1 output enable |
| d2_i | input | 1 | Data pin 2 input (SPI mode receive) |
| bus_addr | output | ADDR_W | Register or program-memory address |
| bus_wdata | output | DATA_W | Write data |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| bus_rdata | input | DATA_W | Register read data, valid the cycle after `reg_rd` |
| pmem_wr | output | 1 | Program-memory write strobe |

## Verification
The bench sweeps every address with a write and a read in both modes. It uses read values that are not bit-palindromic, so a design that mixed up the bit order, or that picked the mode from the wrong clock level, would return mirrored bytes or write to mirrored addresses.

While the shift-register mode is active, the bench drives random-looking junk on `d2_i` and watches the shared pin for overlapping drivers. A design that listened to the wrong pin would corrupt the data, and a design that enabled `dq1_oe` too early would collide with the host's command bits.

Aborted frames check that a lost counter reset would shift the following frame. Extra trailing clocks check that a counter which did not stop would issue a second write.

// File: rtl/srp_pkg.sv
// Package: shared types for the serial register port.
// Assumes nothing beyond being compiled before the modules that import it.
package srp_pkg;
    // Per-transaction wire convention chosen at chip-select activation.
    typedef enum logic {
        XFER_SPI   = 1'b0,
        XFER_SHIFT = 1'b1
    } xfer_mode_e;
endpackage

// File: rtl/srp_sync.sv
// Module: srp_sync
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes every bit toggles slowly relative to clk; bits are independent.
module srp_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/srp_frame.sv
// Module: srp_frame
// Frame engine: detects chip-select and clock edges, latches the mode,
// counts rising clock edges, and assembles the command and data bytes.
// Assumes synchronized inputs and power-of-two byte widths.
module srp_frame
    import srp_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              dq1_s,
    input  logic              d2_s,
    output xfer_mode_e        mode,
    output logic              active,
    output logic [CNT_W-1:0]  cnt,
    output logic              sclk_fall,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [DATA_W-1:0] data_q,
    output logic              cmd_done,
    output logic              data_done
);
    localparam int TOTAL = CMD_W + DATA_W;
    localparam int CI    = $clog2(CMD_W);
    localparam int DI    = $clog2(DATA_W);

    logic          cs_n_d, sclk_d, cs_fall, sclk_rise, din;
    logic [CI-1:0] cmd_idx;
    logic [DI-1:0] dat_off, dat_idx;

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_d <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_n_d <= cs_n_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = cs_n_d & ~cs_n_s;
    assign active    = ~cs_n_s & ~cs_n_d;
    assign sclk_rise = active & ~sclk_d & sclk_s;
    assign sclk_fall = active & sclk_d & ~sclk_s;
    assign din       = (mode == XFER_SHIFT) ? dq1_s : d2_s;

    // Bit positions for the incoming bit; the order depends on the mode.
    always_comb begin
        dat_off = cnt[DI-1:0] - DI'(CMD_W);
        if (mode == XFER_SHIFT) begin
            cmd_idx = cnt[CI-1:0];
            dat_idx = dat_off;
        end else begin
            cmd_idx = CI'(CMD_W - 1) - cnt[CI-1:0];
            dat_idx = DI'(DATA_W - 1) - dat_off;
        end
    end

    // Latch the convention from the clock level at chip-select activation.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= XFER_SPI;
        else if (cs_fall) mode <= sclk_s ? XFER_SHIFT : XFER_SPI;
    end

    // Count rising edges, saturating at the frame length and clearing when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)                        cnt <= '0;
        else if (sclk_rise && cnt < CNT_W'(TOTAL))    cnt <= cnt + 1'b1;
    end

    // Assemble the command and data bytes from the sampled bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else if (sclk_rise) begin
            if (cnt < CNT_W'(CMD_W))      cmd_q[cmd_idx]  <= din;
            else if (cnt < CNT_W'(TOTAL)) data_q[dat_idx] <= din;
        end
    end

    // One-cycle markers, one cycle after the last bit of each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_done  <= 1'b0;
            data_done <= 1'b0;
        end else begin
            cmd_done  <= sclk_rise && (cnt == CNT_W'(CMD_W - 1));
            data_done <= sclk_rise && (cnt == CNT_W'(TOTAL - 1));
        end
    end
endmodule

// File: rtl/srp_txdrv.sv
// Module: srp_txdrv
// Read-data driver: holds the fetched byte and presents one bit per
// falling clock edge on data pin 1. It also generates the pin's output enable.
// Assumes load arrives before the first falling edge of the data byte.
module srp_txdrv
    import srp_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_mode_e        mode,
    input  logic              active,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              sclk_fall,
    input  logic              is_read,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic              dq1_o,
    output logic              dq1_oe
);
    localparam int TOTAL = CMD_W + DATA_W;
    localparam int DI    = $clog2(DATA_W);

    logic [DATA_W-1:0] rd_q;
    logic              dout_q, in_data;
    logic [DI-1:0]     k_off, k_idx;

    assign in_data = (cnt >= CNT_W'(CMD_W)) && (cnt < CNT_W'(TOTAL));

    // Bit of the read byte the host samples at the next rising edge.
    always_comb begin
        k_off = cnt[DI-1:0] - DI'(CMD_W);
        k_idx = (mode == XFER_SHIFT) ? k_off : DI'(DATA_W - 1) - k_off;
    end

    // Load the fetched byte, then step through it on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            dout_q <= 1'b0;
        end else if (!active) begin
            dout_q <= 1'b0;
        end else if (load) begin
            rd_q   <= load_val;
            dout_q <= load_val[k_idx];
        end else if (sclk_fall && in_data && is_read) begin
            dout_q <= rd_q[k_idx];
        end
    end

    assign dq1_oe = active & ((mode == XFER_SPI) | (is_read & in_data));
    assign dq1_o  = dout_q & dq1_oe;
endmodule

// File: rtl/srp_host_port.sv
// Module: srp_host_port (top)
// Serial host port that chooses its wire convention at each chip-select
// activation and turns each 16-bit frame into one register-bus access.
// Assumes the serial clock half-period spans at least six clk cycles and
// that bus_rdata is valid in the cycle after reg_rd.
module srp_host_port
    import srp_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              dq1_i,
    output logic              dq1_o,
    output logic              dq1_oe,
    input  logic              d2_i,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              pmem_wr
);
    localparam int CMD_W  = ADDR_W + 2;
    localparam int RD_BIT = CMD_W - 1;
    localparam int PM_BIT = CMD_W - 2;
    localparam int TOTAL  = CMD_W + DATA_W;
    localparam int CNT_W  = $clog2(TOTAL + 1);

    logic [3:0]        pins_s;
    xfer_mode_e        mode;
    logic              active, sclk_fall, cmd_done, data_done, ld_q;
    logic [CNT_W-1:0]  cnt;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] data_q, load_val;
    logic              is_read, is_prog;

    srp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({d2_i, dq1_i, sclk, cs_n}),
        .sync_o  (pins_s)
    );

    srp_frame #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (pins_s[0]),
        .sclk_s    (pins_s[1]),
        .dq1_s     (pins_s[2]),
        .d2_s      (pins_s[3]),
        .mode      (mode),
        .active    (active),
        .cnt       (cnt),
        .sclk_fall (sclk_fall),
        .cmd_q     (cmd_q),
        .data_q    (data_q),
        .cmd_done  (cmd_done),
        .data_done (data_done)
    );

    assign is_read = cmd_q[RD_BIT];
    assign is_prog = cmd_q[PM_BIT];

    // Remember a pending read so the returned byte is taken one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= 1'b0;
        else        ld_q <= cmd_done & is_read;
    end

    assign load_val = is_prog ? '0 : bus_rdata;

    srp_txdrv #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .active    (active),
        .cnt       (cnt),
        .sclk_fall (sclk_fall),
        .is_read   (is_read),
        .load      (ld_q),
        .load_val  (load_val),
        .dq1_o     (dq1_o),
        .dq1_oe    (dq1_oe)
    );

    assign bus_addr  = cmd_q[ADDR_W-1:0];
    assign bus_wdata = data_q;
    assign reg_rd    = cmd_done & is_read & ~is_prog;
    assign reg_wr    = data_done & ~is_read & ~is_prog;
    assign pmem_wr   = data_done & ~is_read & is_prog;
endmodule

// File: rtl/srp_port_chk.sv
// Module: srp_port_chk
// Protocol checker attached to srp_host_port through bind.
// Assumes it observes the top module's frame state and bus strobes.
module srp_port_chk
    import srp_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             pmem_wr,
    input logic             dq1_oe,
    input logic             active,
    input xfer_mode_e       mode,
    input logic [CNT_W-1:0] cnt,
    input logic             rd_flag
);
    localparam int TOTAL = CMD_W + DATA_W;

    AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && pmem_wr)); // R6

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R12

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !dq1_oe); // R9

    AST_SHIFT_OE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XFER_SHIFT && dq1_oe) |-> rd_flag); // R9

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(TOTAL)); // R12

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(mode)); // R1
endmodule

bind srp_host_port srp_port_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd),
    .pmem_wr (pmem_wr),
    .dq1_oe  (dq1_oe),
    .active  (active),
    .mode    (mode),
    .cnt     (cnt),
    .rd_flag (is_read)
);

// File: tb/srp_host_port_tb.sv
`timescale 1ns/1ps
module srp_host_port_tb_top;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       d2_i = 1'b0;
    logic       host_drive = 1'b0;
    logic       host_val = 1'b0;
    logic       dq1_i, dq1_o, dq1_oe;
    logic [5:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata = 8'h00;
    logic       reg_wr, reg_rd, pmem_wr;

    int checks = 0, errors = 0;
    int wr_cnt = 0, pw_cnt = 0, rd_cnt = 0;
    logic [5:0] wr_addr = '0, pw_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, pw_data = '0;
    int contention = 0, bad_oe = 0, spi_oe_low = 0, read_oe_cycles = 0;
    logic shift_act = 1'b0, spi_win = 1'b0, cur_read = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    // Shared pin with a pull-up.
    assign dq1_i = host_drive ? host_val : (dq1_oe ? dq1_o : 1'b1);

    srp_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .dq1_i(dq1_i), .dq1_o(dq1_o), .dq1_oe(dq1_oe), .d2_i(d2_i),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .bus_rdata(bus_rdata), .pmem_wr(pmem_wr)
    );

    function automatic logic [7:0] reg_val(input logic [5:0] a);
        return 8'(({2'b00, a} * 8'd13) ^ 8'h5A) ^ 8'h01;
    endfunction

    // Register model: read data one cycle after the strobe.
    always @(posedge clk) bus_rdata <= reg_rd ? reg_val(bus_addr) : 8'h00;

    // Strobe and pin monitors, sampled between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr)  begin wr_cnt++; wr_addr = bus_addr; wr_data = bus_wdata; end
            if (pmem_wr) begin pw_cnt++; pw_addr = bus_addr; pw_data = bus_wdata; end
            if (reg_rd)  begin rd_cnt++; rd_addr = bus_addr; end
            if (host_drive && dq1_oe) contention++;
            if (shift_act && dq1_oe && !cur_read) bad_oe++;
            if (shift_act && dq1_oe && cur_read) read_oe_cycles++;
            if (spi_win && !dq1_oe) spi_oe_low++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic halfw();
        repeat (HALF) @(negedge clk);
    endtask

    // One host frame; nbits < 16 aborts, nbits > 16 adds trailing clocks.
    task automatic xfer(input logic shift_m, input logic [7:0] cmd,
                        input logic [7:0] wdat, input int nbits,
                        output logic [7:0] rdat);
        rdat = 8'h00;
        cur_read = cmd[7];
        sclk = shift_m;
        halfw();
        cs_n = 1'b0;
        halfw();
        shift_act = shift_m;
        spi_win = ~shift_m;
        for (int i = 0; i < nbits; i++) begin
            int pos;
            logic b;
            pos = shift_m ? (i % 8) : 7 - (i % 8);
            b = (i < 8) ? cmd[pos] : ((i < 16) ? wdat[pos] : 1'b0);
            if (shift_m) begin
                sclk = 1'b0;
                host_drive = (i < 8) || (i < 16 && !cmd[7]);
                host_val = b;
                d2_i = ~b ^ pos[0];
                halfw();
                if (i >= 8 && i < 16) rdat[pos] = dq1_i;
                sclk = 1'b1;
                if (i == 7 && cmd[7]) host_drive = 1'b0;
                halfw();
            end else begin
                d2_i = b;
                halfw();
                if (i >= 8 && i < 16) rdat[pos] = dq1_i;
                sclk = 1'b1;
                halfw();
                sclk = 1'b0;
            end
        end
        host_drive = 1'b0;
        spi_win = 1'b0;
        halfw();
        cs_n = 1'b1;
        shift_act = 1'b0;
        halfw();
        halfw();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int w0, p0, r0;
        repeat (5) @(negedge clk);
        // R11 reset values
        chk("R11 oe", {31'd0, dq1_oe}, 0);
        chk("R11 dout", {31'd0, dq1_o}, 0);
        chk("R11 strobes", {29'd0, reg_wr, reg_rd, pmem_wr}, 0);
        chk("R11 bus", {18'd0, bus_addr, bus_wdata}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Sweep every address, both modes: write then read.
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 64; a++) begin
                logic [7:0] wd;
                string tag;
                tag = (m == 1) ? "R2 R5 shift write" : "R3 R5 spi write";
                wd = 8'(a * 7 + m * 3) ^ 8'hA5;
                w0 = wr_cnt; p0 = pw_cnt;
                xfer(m[0], {2'b00, 6'(a)}, wd, 16, rd);
                chk(tag, wr_cnt - w0, 1);
                chk("R4 R5 write address", {26'd0, wr_addr}, a);
                chk("R5 write data", {24'd0, wr_data}, {24'd0, wd});
                chk("R6 no program write", pw_cnt - p0, 0);
                r0 = rd_cnt; w0 = wr_cnt;
                xfer(m[0], {2'b10, 6'(a)}, 8'h00, 16, rd);
                chk("R1 R7 read strobe", rd_cnt - r0, 1);
                chk("R4 R7 read address", {26'd0, rd_addr}, a);
                chk((m == 1) ? "R1 R2 R7 shift read data" : "R1 R3 R7 spi read data",
                    {24'd0, rd}, {24'd0, reg_val(6'(a))});
                chk("R7 read no write", wr_cnt - w0, 0);
            end
        end
        chk("R2 no pin contention", contention, 0);
        chk("R9 oe only in read data", bad_oe, 0);
        chk("R9 oe seen during reads", {31'd0, read_oe_cycles > 0}, 1);
        chk("R3 spi oe held", spi_oe_low, 0);

        // Program-memory space.
        for (int m = 0; m < 2; m++) begin
            w0 = wr_cnt; p0 = pw_cnt; r0 = rd_cnt;
            xfer(m[0], 8'h55, 8'h3C, 16, rd);
            chk("R6 program write strobe", pw_cnt - p0, 1);
            chk("R6 no register write", wr_cnt - w0, 0);
            chk("R4 R6 program address", {26'd0, pw_addr}, 32'h15);
            chk("R6 program data", {24'd0, pw_data}, 32'h3C);
            xfer(m[0], 8'hD5, 8'h00, 16, rd);
            chk("R8 no register read", rd_cnt - r0, 0);
            chk("R8 program read zero", {24'd0, rd}, 0);
        end

        // Aborted frames, then a clean frame in each mode.
        for (int m = 0; m < 2; m++) begin
            w0 = wr_cnt;
            xfer(m[0], 8'h21, 8'hC3, 12, rd);
            chk("R10 abort no write", wr_cnt - w0, 0);
            xfer(m[0], 8'h2E, 8'h96, 16, rd);
            chk("R10 fresh frame write", wr_cnt - w0, 1);
            chk("R10 fresh frame address", {26'd0, wr_addr}, 32'h2E);
            chk("R10 fresh frame data", {24'd0, wr_data}, 32'h96);
        end
        xfer(1'b1, 8'h83, 8'h00, 11, rd);
        repeat (4) @(negedge clk);
        chk("R9 R10 oe released after abort", {31'd0, dq1_oe}, 0);

        // Trailing clocks after a complete frame.
        for (int m = 0; m < 2; m++) begin
            w0 = wr_cnt;
            xfer(m[0], 8'h0B, 8'h71, 19, rd);
            chk("R12 single write with extra clocks", wr_cnt - w0, 1);
            chk("R12 data unchanged by extra clocks", {24'd0, wr_data}, 32'h71);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule